// File: doc/BRIEF.md
# Bit-Serial Shifted-Operand Subtractor

This cell is one node of a bit-serialized FIR adder tree. It takes two operands as serial streams, least significant bit first, one bit per clock. It produces, also LSB first, the difference between one operand arithmetically shifted right by a fixed amount and the other operand. The shift and the negation cost no extra datapath. The unshifted operand is delayed so that the shifted operand's dropped low bits never reach the adder. The shifted operand's sign bit is held and replayed once its live bits run out. Subtraction uses inverted bits and a carry preset at the start of each word.

Each frame lasts `DATA_W + 1` cycles. The operands occupy the first `DATA_W` cycles. The extra pad cycle gives room for the `DATA_W + 1`-bit result, which cannot wrap. A one-cycle pulse on `sync_i` marks frame cycle 0. An internal modulo-frame counter regenerates every word-boundary control from that pulse, and it keeps running on its own when no further pulse arrives. The result is registered. A companion pulse marks its first bit, so the next serial node can align to it.

Top module: `serial_shift_sub`

## Requirements
- R1: Per frame, the serial result equals `(shf >>> SHIFT) - min` as a `DATA_W + 1`-bit two's complement number, where `shf` and `min` are the signed `DATA_W`-bit operand words. The result is emitted LSB first, one bit per cycle.
- R2: A frame is `DATA_W + 1` cycles. Operand bit k is sampled on frame cycle k for k in 0..`DATA_W`-1. Both serial inputs are ignored on the pad cycle `DATA_W`.
- R3: Result bit k appears on `dif_o` right after the clock edge that closes frame cycle k+`SHIFT`, counted from the sync cycle and running into the next frame when needed. `dif_start_o` is high exactly while result bit 0 is shown.
- R4: `sync_i` high forces the current cycle to be frame cycle 0 from any counter state. Without it, the frame counter wraps by itself every `DATA_W + 1` cycles.
- R5: No carry passes from one result word to the next, including when extreme words run back to back.
- R6: The shifted operand is sign-extended: its top `SHIFT` result positions and the pad position repeat its sign bit.
- R7: While reset is asserted, `dif_o` and `dif_start_o` are 0.
- R8: The extreme operand pairs give the full-range results, +143 and -143 for 8-bit words with a shift of 3, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Pulse on frame cycle 0 |
| min_i | input | 1 | Serial subtrahend bit, LSB first |
| shf_i | input | 1 | Serial bit of the operand that is shifted right, LSB first |
| dif_o | output | 1 | Serial result bit, LSB first, registered |
| dif_start_o | output | 1 | High with result bit 0 |

## Verification
The bench builds the cell with 8-bit words and a shift of 3. This gives a 9-cycle frame, and the held sign fills four result positions. With 8-bit words every extreme pair can be listed outright, including both full-range results and the all-ones and most-negative words. The shift of 3 is large enough for the result tail of one word to overlap the first operand bits of the next. That overlap is what exposes carry or sign leakage between frames and lets pad-cycle garbage and mid-frame resynchronisation be exercised.

// File: rtl/serial_shift_sub_pkg.sv
package serial_shift_sub_pkg;

    // Per-cycle control decoded from the frame counter
    typedef struct packed {
        logic first;    // adder works on result bit 0 this cycle
        logic b_live;   // shifted operand bit comes straight from the pin
        logic a_ext;    // adder works on the pad result bit: use held sign
        logic cap;      // last operand bit is on the pins: capture signs
    } sss_ctl_t;

    // Registered state of the serial full-adder cell
    typedef struct packed {
        logic carry;
        logic dif;
        logic start;
    } sss_fa_t;

endpackage

// File: rtl/sss_frame_ctl.sv
module sss_frame_ctl
    import serial_shift_sub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SHIFT  = 3
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     sync_i,
    output sss_ctl_t ctl_o
);
    localparam int FRAME   = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME);
    // frame cycle on which the adder handles the pad result bit
    localparam int EXT_CNT = (DATA_W + SHIFT) % FRAME;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] cur;

    always_comb begin
        st_d = st_q;
        cur  = sync_i ? '0 : st_q.cnt;
        if (cur == CNT_W'(FRAME - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cur + 1'b1;
        end
        ctl_o.first  = (cur == CNT_W'(SHIFT));
        ctl_o.b_live = (cur >= CNT_W'(SHIFT)) && (cur <= CNT_W'(DATA_W - 1));
        ctl_o.a_ext  = (cur == CNT_W'(EXT_CNT));
        ctl_o.cap    = (cur == CNT_W'(DATA_W - 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sss_operand_align.sv
module sss_operand_align
    import serial_shift_sub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SHIFT  = 3
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     min_i,
    input  logic     shf_i,
    input  sss_ctl_t ctl_i,
    output logic     min_bit_o,
    output logic     shf_bit_o
);
    localparam int DLY_W = (SHIFT > 0) ? SHIFT : 1;

    typedef struct packed {
        logic [DLY_W-1:0] dly;       // realigns the unshifted operand
        logic             min_sign;  // held sign of the unshifted operand
        logic             shf_sign;  // held sign of the shifted operand
    } state_t;

    state_t st_d, st_q;
    logic   min_late;

    generate
        if (SHIFT > 0) begin : g_delay
            assign min_late = st_q.dly[DLY_W-1];
        end else begin : g_direct
            assign min_late = min_i;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.dly = DLY_W'({st_q.dly, min_i});
        if (ctl_i.cap) begin
            st_d.min_sign = min_i;
            st_d.shf_sign = shf_i;
        end
        min_bit_o = ctl_i.a_ext  ? st_q.min_sign : min_late;
        shf_bit_o = ctl_i.b_live ? shf_i         : st_q.shf_sign;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sss_fa_cell.sv
module sss_fa_cell
    import serial_shift_sub_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic min_bit_i,
    input  logic shf_bit_i,
    input  logic first_i,
    output logic dif_o,
    output logic start_o
);
    sss_fa_t st_d, st_q;
    logic    x, y, cin, half;

    always_comb begin
        st_d     = st_q;
        x        = shf_bit_i;
        y        = ~min_bit_i;              // negate: invert, +1 via carry
        cin      = first_i ? 1'b1 : st_q.carry;
        half     = x ^ y;
        st_d.dif   = half ^ cin;
        st_d.carry = (x & y) | (cin & half);
        st_d.start = first_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dif_o   = st_q.dif;
    assign start_o = st_q.start;

endmodule

// File: rtl/serial_shift_sub.sv
module serial_shift_sub
    import serial_shift_sub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SHIFT  = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    input  logic min_i,
    input  logic shf_i,
    output logic dif_o,
    output logic dif_start_o
);
    sss_ctl_t ctl;
    logic     min_bit, shf_bit;

    sss_frame_ctl #(.DATA_W(DATA_W), .SHIFT(SHIFT)) ctl_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_i),
        .ctl_o  (ctl)
    );

    sss_operand_align #(.DATA_W(DATA_W), .SHIFT(SHIFT)) align_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .min_i     (min_i),
        .shf_i     (shf_i),
        .ctl_i     (ctl),
        .min_bit_o (min_bit),
        .shf_bit_o (shf_bit)
    );

    sss_fa_cell fa_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .min_bit_i (min_bit),
        .shf_bit_i (shf_bit),
        .first_i   (ctl.first),
        .dif_o     (dif_o),
        .start_o   (dif_start_o)
    );

endmodule

// File: rtl/serial_shift_sub_chk.sv
module serial_shift_sub_chk #(
    parameter int DATA_W = 8,
    parameter int SHIFT  = 3
) (
    input logic clk_i,
    input logic rst_ni,
    input logic sync_i,
    input logic dif_o,
    input logic dif_start_o
);
    localparam int FRAME   = DATA_W + 1;
    localparam int AGE_MAX = FRAME + SHIFT + 1;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam int GAP_W   = $clog2(FRAME + 1);

    logic [AGE_W-1:0] sync_age_q;
    logic [GAP_W-1:0] gap_q;
    logic             start_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_age_q   <= AGE_W'(AGE_MAX);
            gap_q        <= '0;
            start_seen_q <= 1'b0;
        end else begin
            if (sync_i) begin
                sync_age_q <= '0;
            end else if (sync_age_q != AGE_W'(AGE_MAX)) begin
                sync_age_q <= sync_age_q + 1'b1;
            end
            if (dif_start_o) begin
                gap_q        <= '0;
                start_seen_q <= 1'b1;
            end else if (gap_q != GAP_W'(FRAME)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R3: the start marker lasts a single cycle
    assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dif_start_o |=> !dif_start_o);

    // R4: a sync pulse yields a start marker SHIFT+1 cycles later
    assert_start_after_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_age_q == AGE_W'(SHIFT)) |-> dif_start_o);

    // R2: with no recent sync, markers recur once per frame
    assert_frame_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_seen_q && gap_q == GAP_W'(FRAME - 1) &&
         sync_age_q >= AGE_W'(FRAME + SHIFT)) |-> dif_start_o);

    // R1: outputs are always driven to known levels
    assert_known_out_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown({dif_o, dif_start_o}));

endmodule

bind serial_shift_sub serial_shift_sub_chk #(.DATA_W(DATA_W), .SHIFT(SHIFT)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .dif_o       (dif_o),
    .dif_start_o (dif_start_o)
);

// File: tb/serial_shift_sub_tb_top.sv
module serial_shift_sub_tb_top;
    localparam int DW = 8;
    localparam int SH = 3;
    localparam int FR = DW + 1;
    localparam int NV = 12;

    // {min word, shifted word}
    localparam logic [15:0] VEC [NV] = '{
        16'h00_00, 16'h01_00, 16'h00_08, 16'h80_7f,
        16'h7f_80, 16'hff_ff, 16'h80_80, 16'h7f_7f,
        16'h55_aa, 16'h01_f8, 16'h00_07, 16'h00_f9
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sync, a_bit, b_bit;
    logic dif, dstart;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [DW-1:0] opa [64];
    logic [DW-1:0] opb [64];

    serial_shift_sub #(.DATA_W(DW), .SHIFT(SH)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sync_i      (sync),
        .min_i       (a_bit),
        .shf_i       (b_bit),
        .dif_o       (dif),
        .dif_start_o (dstart)
    );

    function automatic logic [DW:0] ref_dif(logic [DW-1:0] a, logic [DW-1:0] b);
        int ai = int'($signed(a));
        int bi = int'($signed(b));
        int r  = (bi >>> SH) - ai;
        return r[DW:0];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // pad_mode: 0 random, 1 all ones on the pad cycle
    task automatic stream(int nfr, bit sync_all, bit pad_mode, string req);
        logic [DW:0] got = '0;
        int total = nfr * FR + SH + 2;
        for (int n = 0; n < total; n++) begin
            @(negedge clk);
            if (n >= 1) begin
                int m = n - 1 - SH;
                if (m >= 0 && m < nfr * FR) begin
                    int j = m / FR;
                    int k = m % FR;
                    got[k] = dif;
                    check(dstart == (k == 0), "R3", "start marker", int'(dstart), int'(k == 0));
                    if (k == FR - 1) begin
                        check(got == ref_dif(opa[j], opb[j]), req, "result word",
                              int'($signed(got)), int'($signed(ref_dif(opa[j], opb[j]))));
                    end
                end
            end
            if (n < nfr * FR) begin
                int j = n / FR;
                int k = n % FR;
                sync = (k == 0) && (sync_all || j == 0);
                if (k < DW) begin
                    a_bit = opa[j][k];
                    b_bit = opb[j][k];
                end else begin
                    a_bit = pad_mode ? 1'b1 : 1'($urandom);
                    b_bit = pad_mode ? 1'b1 : 1'($urandom);
                end
            end else begin
                sync  = 1'b0;
                a_bit = 1'($urandom);
                b_bit = 1'($urandom);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sync = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
        repeat (3) @(negedge clk);
        // R7: outputs quiet under reset
        check(dif == 1'b0,    "R7", "dif in reset",   int'(dif), 0);
        check(dstart == 1'b0, "R7", "start in reset", int'(dstart), 0);
        rst_n = 1'b1;

        // table walk: R1, R6, R8 extremes and sign cases
        for (int i = 0; i < NV; i++) begin
            opa[i] = VEC[i][15:8];
            opb[i] = VEC[i][7:0];
        end
        stream(NV, 1'b1, 1'b0, "R1/R6/R8");

        // R5: extreme words back to back
        for (int i = 0; i < 10; i++) begin
            opa[i] = (i % 2 == 0) ? 8'h80 : 8'h7f;
            opb[i] = (i % 2 == 0) ? 8'h7f : 8'h80;
        end
        stream(10, 1'b1, 1'b0, "R5");

        // R2: pad cycle driven high must not matter
        for (int i = 0; i < 8; i++) begin
            opa[i] = 8'($urandom);
            opb[i] = 8'($urandom);
        end
        stream(8, 1'b1, 1'b1, "R2");

        // R1: random words
        for (int i = 0; i < 40; i++) begin
            opa[i] = 8'($urandom);
            opb[i] = 8'($urandom);
        end
        stream(40, 1'b1, 1'b0, "R1");

        // R4: single sync then free-running frames
        for (int i = 0; i < 20; i++) begin
            opa[i] = 8'($urandom);
            opb[i] = 8'($urandom);
        end
        stream(20, 1'b0, 1'b0, "R4");

        // R4: resync in the middle of a frame
        @(negedge clk); sync = 1'b1; a_bit = 1'b1; b_bit = 1'b0;
        repeat (4) begin
            @(negedge clk); sync = 1'b0; a_bit = 1'($urandom); b_bit = 1'($urandom);
        end
        for (int i = 0; i < 6; i++) begin
            opa[i] = 8'($urandom);
            opb[i] = 8'($urandom);
        end
        stream(6, 1'b1, 1'b0, "R4");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule